// File: doc/BRIEF.md
# Shared RAM Arbiter with Protected Slave Windows

This block controls one synchronous static RAM that serves two masters: a local processor port and a slave port facing an external system bus. The processor always owns the RAM when it asks for it. Its accesses complete with no wait states, and its read data returns on the next cycle. The arbiter accepts a slave request and holds it pending with its address, data, byte enables and address modifier latched. It performs the RAM access in the first cycle in which the processor is idle. Processor timing is therefore the same whether or not external traffic is present.

Three windows decide which slave addresses reach the RAM. Software loads these through a small configuration port. Each window has a base page, a size in pages and a RAM offset page, all in 4 KB units. Each window also has a 6-bit address-modifier code, a flag that compares only the low 24 address bits, and separate bits that block reads and writes. A slave access that matches no window, or that breaks the protection of the window it matches, gets no acknowledge. The RAM is not touched, and a fault strobe is raised for one cycle instead.

Top module: `dpram_arb`

## Requirements
- R1: A processor access (`cpu_req` high) always drives the RAM in that cycle. Its read data appears on `cpu_rdata` in the following cycle, even while a slave access is pending.
- R2: A slave access uses the RAM only in a cycle with `cpu_req` low. `s_ack` is never high unless `cpu_req` was low in the cycle before.
- R3: Window match uses 4 KB pages. An address hits window i when base_i <= page < base_i + size_i. When windows overlap, the lowest window index wins.
- R4: A window matches only when `s_am` equals its 6-bit code, in control bits [5:0]. When control bit 8 is set, only address bits [23:0] are compared, and the upper bits are taken as zero.
- R5: A hit reaches RAM word ((address - base*4096) + offset*4096) bits [RAM_AW+1:2], and the result wraps in the RAM size.
- R6: Control bit 6 blocks reads and control bit 7 blocks writes. A blocked access gets no `s_ack`, raises `s_fault` for one cycle and leaves the RAM unchanged.
- R7: A slave access that hits no window gets no `s_ack` and raises `s_fault` one cycle after `s_req` is seen.
- R8: The slave request is latched on the first clock with `s_req` high in the idle state. The slave inputs may then change. `s_ack` is a single-cycle pulse. It arrives the cycle after the first processor-idle cycle following capture, and no earlier than two cycles after `s_req`, with `s_rdata` valid alongside it. A new request is taken only after `s_req` has been low.
- R9: The configuration port writes on `cfg_we`, choosing the window with `cfg_win` and the field with `cfg_field`: 0 base page, 1 size in pages, 2 offset page (page fields in `cfg_wdata[19:0]`), 3 control. A size of 0 disables a window. After reset all windows are disabled and `s_ack`/`s_fault` are low.
- R10: Byte enables (bit n covers data bits 8n+7:8n) select which bytes a write changes, on both ports, so 8-, 16- and 32-bit transfers are supported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access this cycle |
| cpu_we | input | 1 | Processor write |
| cpu_be | input | 4 | Processor byte enables |
| cpu_addr | input | RAM_AW | Processor word address |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rdata | output | 32 | Processor read data, one cycle after request |
| cfg_we | input | 1 | Window register write strobe |
| cfg_win | input | 2 | Window select |
| cfg_field | input | 2 | Field select |
| cfg_wdata | input | 32 | Window register data |
| s_req | input | 1 | Slave request, held until acknowledge or fault |
| s_we | input | 1 | Slave write |
| s_am | input | 6 | Slave address modifier |
| s_addr | input | 32 | Slave byte address |
| s_be | input | 4 | Slave byte enables |
| s_wdata | input | 32 | Slave write data |
| s_ack | output | 1 | Slave acknowledge pulse |
| s_fault | output | 1 | Protection or decode fault pulse |
| s_rdata | output | 32 | Slave read data, valid with `s_ack` |

## Verification
The bench builds the block with RAM_AW = 11, which gives an 8 KB RAM of two 4 KB pages, and with the default three windows. Any window whose offset plus relative page passes the second page therefore wraps back into page zero, so the aliasing of R5 becomes visible with a model small enough to fill completely. Two windows overlap on one page, which exercises the priority of R3. Processor busy runs of up to five cycles push the slave acknowledge to every timing position that R8 allows.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int PAGE_SHIFT = 12;
  localparam int PG_W       = 32 - PAGE_SHIFT;
  localparam int AM_W       = 6;

  typedef enum logic [1:0] {
    FLD_BASE = 2'd0,
    FLD_SIZE = 2'd1,
    FLD_OFFS = 2'd2,
    FLD_CTRL = 2'd3
  } cfg_field_e;

  typedef struct packed {
    logic            a24;
    logic            no_wr;
    logic            no_rd;
    logic [AM_W-1:0] am;
  } win_ctl_t;

  typedef enum logic [1:0] {
    SL_IDLE = 2'd0,
    SL_PEND = 2'd1,
    SL_RESP = 2'd2,
    SL_DONE = 2'd3
  } sl_state_e;
endpackage

// File: rtl/dpr_window.sv
module dpr_window
  import dpr_pkg::*;
#(
  parameter int RAM_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_field,
  input  logic [31:0]       wr_data,
  input  logic [31:0]       q_addr,
  input  logic [AM_W-1:0]   q_am,
  input  logic              q_we,
  output logic              hit,
  output logic              deny,
  output logic [RAM_AW-1:0] ram_word
);
  localparam int CTL_W = $bits(win_ctl_t);

  logic [PG_W-1:0] base_q, base_d, size_q, size_d, offs_q, offs_d;
  win_ctl_t        ctl_q, ctl_d;

  always_comb begin
    base_d = base_q;
    size_d = size_q;
    offs_d = offs_q;
    ctl_d  = ctl_q;
    if (wr_en) begin
      case (cfg_field_e'(wr_field))
        FLD_BASE: base_d = wr_data[PG_W-1:0];
        FLD_SIZE: size_d = wr_data[PG_W-1:0];
        FLD_OFFS: offs_d = wr_data[PG_W-1:0];
        default:  ctl_d  = win_ctl_t'(wr_data[CTL_W-1:0]);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= '0;
      offs_q <= '0;
      ctl_q  <= '0;
    end else begin
      base_q <= base_d;
      size_q <= size_d;
      offs_q <= offs_d;
      ctl_q  <= ctl_d;
    end
  end

  logic [31:0]     eff_addr;
  logic [PG_W-1:0] page, rel_pg, ram_pg;

  always_comb begin
    eff_addr = ctl_q.a24 ? {8'h00, q_addr[23:0]} : q_addr;
    page     = eff_addr[31:PAGE_SHIFT];
    rel_pg   = page - base_q;
    ram_pg   = rel_pg + offs_q;
    hit      = (page >= base_q) && (rel_pg < size_q) && (q_am == ctl_q.am);
    deny     = q_we ? ctl_q.no_wr : ctl_q.no_rd;
    ram_word = RAM_AW'({ram_pg, eff_addr[PAGE_SHIFT-1:2]});
  end

  // R9
  disabled_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (size_q == '0) |-> !hit);
endmodule

// File: rtl/dpr_mem.sv
module dpr_mem #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            en,
  input  logic            we,
  input  logic [DW/8-1:0] be,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata
);
  localparam int LANES = DW / 8;
  localparam int DEPTH = 1 << AW;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic [7:0] lane_mem [DEPTH];
    logic [7:0] lane_q;

    always_ff @(posedge clk) begin
      if (en && we && be[b]) lane_mem[addr] <= wdata[b*8 +: 8];
      if (en && !we)         lane_q         <= lane_mem[addr];
    end

    assign rdata[b*8 +: 8] = lane_q;
  end
endmodule

// File: rtl/dpram_arb.sv
module dpram_arb
  import dpr_pkg::*;
#(
  parameter int RAM_AW = 10,
  parameter int N_WIN  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [3:0]        cpu_be,
  input  logic [RAM_AW-1:0] cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic [31:0]       cpu_rdata,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_win,
  input  logic [1:0]        cfg_field,
  input  logic [31:0]       cfg_wdata,
  input  logic              s_req,
  input  logic              s_we,
  input  logic [5:0]        s_am,
  input  logic [31:0]       s_addr,
  input  logic [3:0]        s_be,
  input  logic [31:0]       s_wdata,
  output logic              s_ack,
  output logic              s_fault,
  output logic [31:0]       s_rdata
);
  localparam int DW   = 32;
  localparam int BE_W = DW / 8;

  sl_state_e         st_q, st_d;
  logic [31:0]       la_addr_q, la_addr_d, la_wdata_q, la_wdata_d;
  logic [AM_W-1:0]   la_am_q, la_am_d;
  logic [BE_W-1:0]   la_be_q, la_be_d;
  logic              la_we_q, la_we_d;

  logic [N_WIN-1:0]  win_hit, win_deny;
  logic [RAM_AW-1:0] win_word [N_WIN];

  for (genvar i = 0; i < N_WIN; i++) begin : g_win
    dpr_window #(.RAM_AW(RAM_AW)) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we && (cfg_win == 2'(i))),
      .wr_field (cfg_field),
      .wr_data  (cfg_wdata),
      .q_addr   (la_addr_q),
      .q_am     (la_am_q),
      .q_we     (la_we_q),
      .hit      (win_hit[i]),
      .deny     (win_deny[i]),
      .ram_word (win_word[i])
    );
  end

  logic              any_hit, sel_deny, grant_ok, slave_go;
  logic [RAM_AW-1:0] sel_word;

  always_comb begin
    any_hit  = 1'b0;
    sel_deny = 1'b0;
    sel_word = '0;
    for (int i = N_WIN - 1; i >= 0; i--) begin
      if (win_hit[i]) begin
        any_hit  = 1'b1;
        sel_deny = win_deny[i];
        sel_word = win_word[i];
      end
    end
  end

  assign grant_ok = any_hit && !sel_deny;
  assign slave_go = (st_q == SL_PEND) && grant_ok && !cpu_req;

  always_comb begin
    st_d       = st_q;
    la_addr_d  = la_addr_q;
    la_wdata_d = la_wdata_q;
    la_am_d    = la_am_q;
    la_be_d    = la_be_q;
    la_we_d    = la_we_q;
    case (st_q)
      SL_IDLE: if (s_req) begin
        st_d       = SL_PEND;
        la_addr_d  = s_addr;
        la_wdata_d = s_wdata;
        la_am_d    = s_am;
        la_be_d    = s_be;
        la_we_d    = s_we;
      end
      SL_PEND: begin
        if (!grant_ok)     st_d = SL_DONE;
        else if (slave_go) st_d = SL_RESP;
      end
      SL_RESP: st_d = SL_DONE;
      default: if (!s_req) st_d = SL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= SL_IDLE;
      la_addr_q  <= '0;
      la_wdata_q <= '0;
      la_am_q    <= '0;
      la_be_q    <= '0;
      la_we_q    <= 1'b0;
    end else begin
      st_q       <= st_d;
      la_addr_q  <= la_addr_d;
      la_wdata_q <= la_wdata_d;
      la_am_q    <= la_am_d;
      la_be_q    <= la_be_d;
      la_we_q    <= la_we_d;
    end
  end

  logic              mem_en, mem_we;
  logic [BE_W-1:0]   mem_be;
  logic [RAM_AW-1:0] mem_addr;
  logic [DW-1:0]     mem_wdata, mem_q;

  always_comb begin
    mem_en    = cpu_req || slave_go;
    mem_we    = cpu_req ? cpu_we    : la_we_q;
    mem_be    = cpu_req ? cpu_be    : la_be_q;
    mem_addr  = cpu_req ? cpu_addr  : sel_word;
    mem_wdata = cpu_req ? cpu_wdata : la_wdata_q;
  end

  dpr_mem #(.AW(RAM_AW), .DW(DW)) u_mem (
    .clk   (clk),
    .en    (mem_en),
    .we    (mem_we),
    .be    (mem_be),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (mem_q)
  );

  assign cpu_rdata = mem_q;
  assign s_ack     = (st_q == SL_RESP);
  assign s_fault   = (st_q == SL_PEND) && !grant_ok;
  assign s_rdata   = s_ack ? mem_q : '0;

  // R1
  cpu_owns_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> (mem_en && mem_addr == cpu_addr && mem_we == cpu_we));
  // R2
  ack_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ack |-> $past(!cpu_req));
  // R6
  deny_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SL_PEND && any_hit && sel_deny && !cpu_req) |-> !mem_en);
  // R8
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ack |=> !s_ack);
  // R8
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SL_PEND) |=> $stable(la_addr_q) && $stable(la_wdata_q));
  // R6
  fault_ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({s_ack, s_fault}));
endmodule

// File: tb/dpram_arb_test.sv
module dpram_arb_test;
  localparam int AW    = 11;
  localparam int WORDS = 1 << AW;

  logic          clk, rst_n;
  logic          cpu_req, cpu_we;
  logic [3:0]    cpu_be;
  logic [AW-1:0] cpu_addr;
  logic [31:0]   cpu_wdata, cpu_rdata;
  logic          cfg_we;
  logic [1:0]    cfg_win, cfg_field;
  logic [31:0]   cfg_wdata;
  logic          s_req, s_we;
  logic [5:0]    s_am;
  logic [31:0]   s_addr, s_wdata, s_rdata;
  logic [3:0]    s_be;
  logic          s_ack, s_fault;

  dpram_arb #(.RAM_AW(AW), .N_WIN(3)) uut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [31:0] mdl [WORDS];
  logic [19:0] t_base [3];
  logic [19:0] t_size [3];
  logic [19:0] t_offs [3];
  logic [8:0]  t_ctl  [3];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] be);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
    return r;
  endfunction

  function automatic void decode(input logic [31:0] a, input logic [5:0] am, input bit we,
                                 output int idx, output bit deny, output int word);
    logic [31:0] ea;
    logic [19:0] rel;
    logic [29:0] w;
    idx = -1; deny = 0; word = 0;
    for (int i = 0; i < 3; i++) begin
      ea  = t_ctl[i][8] ? {8'h00, a[23:0]} : a;
      rel = ea[31:12] - t_base[i];
      if (idx < 0 && t_size[i] != 0 && am == t_ctl[i][5:0] &&
          ea[31:12] >= t_base[i] && rel < t_size[i]) begin
        idx  = i;
        deny = we ? t_ctl[i][7] : t_ctl[i][6];
        w    = {rel + t_offs[i], ea[11:2]};
        word = int'(w) % WORDS;
      end
    end
  endfunction

  task automatic cfg(input int w, input int f, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_win = 2'(w); cfg_field = 2'(f); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (f)
      0: t_base[w] = d[19:0];
      1: t_size[w] = d[19:0];
      2: t_offs[w] = d[19:0];
      default: t_ctl[w] = d[8:0];
    endcase
  endtask

  task automatic cpu_wr(input int a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = AW'(a); cpu_wdata = d; cpu_be = be;
    @(negedge clk);
    cpu_req = 1'b0;
    mdl[a] = merge(mdl[a], d, be);
  endtask

  task automatic cpu_rd(input int a, input string req);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = AW'(a);
    @(negedge clk);
    cpu_req = 1'b0;
    check(cpu_rdata === mdl[a], req, cpu_rdata, mdl[a]);
  endtask

  task automatic slv(input logic [31:0] a, input logic [5:0] am, input bit we, input logic [3:0] be,
                     input logic [31:0] d, input int busy, input string req);
    int idx, word, ack_at, flt_at, exp_at;
    bit deny, cpu_ok;
    int rd_a;
    logic [31:0] got;
    decode(a, am, we, idx, deny, word);
    rd_a = int'($urandom_range(WORDS - 1));
    @(negedge clk);
    s_req = 1'b1; s_we = we; s_am = am; s_addr = a; s_be = be; s_wdata = d;
    if (busy > 0) begin
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = AW'(rd_a);
    end
    ack_at = -1; flt_at = -1; cpu_ok = 1; got = '0;
    for (int n = 1; n <= 20 && ack_at < 0 && flt_at < 0; n++) begin
      @(negedge clk);
      if (n <= busy && cpu_rdata !== mdl[rd_a]) cpu_ok = 0;
      if (n == busy) cpu_req = 1'b0;
      if (s_ack) begin ack_at = n; got = s_rdata; end
      if (s_fault) flt_at = n;
      s_addr = $urandom; s_wdata = $urandom; s_am = 6'($urandom); s_be = 4'($urandom);
    end
    cpu_req = 1'b0;
    if (busy > 0) check(cpu_ok, {req, " R1 cpu read during pending slave"}, 32'(cpu_ok), 32'd1);
    if (idx < 0 || deny) begin
      check(flt_at == 1 && ack_at < 0, {req, " fault"}, 32'(flt_at), 32'd1);
    end else begin
      exp_at = (busy + 1 > 2) ? busy + 1 : 2;
      check(ack_at == exp_at && flt_at < 0, {req, " R2 R8 ack cycle"}, 32'(ack_at), 32'(exp_at));
      if (we) mdl[word] = merge(mdl[word], d, be);
      else    check(got === mdl[word], {req, " slave read data"}, got, mdl[word]);
    end
    @(negedge clk);
    s_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int idx, word;
    bit deny;
    void'($urandom(32'd4711));
    for (int i = 0; i < 3; i++) begin t_base[i] = '0; t_size[i] = '0; t_offs[i] = '0; t_ctl[i] = '0; end
    rst_n = 1'b0; cpu_req = 0; cpu_we = 0; cpu_be = 0; cpu_addr = '0; cpu_wdata = '0;
    cfg_we = 0; cfg_win = 0; cfg_field = 0; cfg_wdata = '0;
    s_req = 0; s_we = 0; s_am = '0; s_addr = '0; s_be = '0; s_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(!s_ack && !s_fault, "R9 reset outputs", {30'd0, s_ack, s_fault}, 32'd0);
    // R9 windows disabled after reset, R7 miss
    slv(32'h0010_0000, 6'h00, 0, 4'hF, 0, 0, "R9 R7 disabled after reset");

    for (int a = 0; a < WORDS; a++) cpu_wr(a, $urandom, 4'hF);

    cfg(0, 0, 32'h100); cfg(0, 1, 32'd2); cfg(0, 2, 32'd0); cfg(0, 3, {23'd0, 9'h00D});
    cfg(1, 0, 32'h101); cfg(1, 1, 32'd2); cfg(1, 2, 32'd1); cfg(1, 3, {23'd0, 9'h08D});
    cfg(2, 0, 32'h040); cfg(2, 1, 32'd1); cfg(2, 2, 32'd1); cfg(2, 3, {23'd0, 9'h179});

    // R3 overlap page resolved to lowest index
    decode(32'h0010_1040, 6'h0D, 0, idx, deny, word);
    check(idx == 0, "R3 overlap priority model", 32'(idx), 32'd0);
    slv(32'h0010_1040, 6'h0D, 1, 4'hF, 32'hCAFE_0001, 0, "R3 overlap write via window 0");
    cpu_rd(word, "R3 R5 overlap write landed");
    // R5 offset translation with wrap
    slv(32'h0010_2008, 6'h0D, 0, 4'hF, 0, 0, "R5 window 1 read");
    // R6 write blocked, RAM unchanged
    decode(32'h0010_2010, 6'h0D, 1, idx, deny, word);
    slv(32'h0010_2010, 6'h0D, 1, 4'hF, 32'hDEAD_BEEF, 0, "R6 blocked write");
    cpu_rd(word, "R6 RAM unchanged after blocked write");
    // R4 short addressing: upper bits ignored
    slv(32'hAB04_0010, 6'h39, 1, 4'hF, 32'h1234_5678, 0, "R4 a24 write");
    decode(32'h0004_0010, 6'h39, 1, idx, deny, word);
    cpu_rd(word, "R4 a24 write landed");
    slv(32'h5504_0010, 6'h39, 0, 4'hF, 0, 0, "R6 a24 read blocked");
    slv(32'h0004_0010, 6'h0D, 1, 4'hF, 0, 0, "R4 wrong modifier misses");
    slv(32'h0010_3000, 6'h0D, 0, 4'hF, 0, 0, "R7 page past windows");
    // R8 R2 long processor busy run
    slv(32'h0010_0100, 6'h0D, 0, 4'hF, 0, 5, "R8 busy five");
    slv(32'h0010_0104, 6'h0D, 1, 4'hF, 0, 1, "R8 busy one");
    // R10 byte lanes
    slv(32'h0010_0200, 6'h0D, 1, 4'b0010, 32'hA5A5_A5A5, 0, "R10 slave byte write");
    decode(32'h0010_0200, 6'h0D, 1, idx, deny, word);
    cpu_rd(word, "R10 slave byte lane");
    cpu_wr(word, 32'h7700_0000, 4'b1000);
    cpu_rd(word, "R10 cpu byte lane");
    // R9 size zero disables window
    cfg(1, 1, 32'd0);
    slv(32'h0010_2008, 6'h0D, 0, 4'hF, 0, 0, "R9 disabled window");
    cfg(1, 1, 32'd2);

    for (int k = 0; k < 150; k++) begin
      logic [31:0] a;
      logic [5:0] am;
      int sel = int'($urandom_range(5));
      case (sel)
        0, 1, 2: a = {20'h100 + 20'($urandom_range(3)), 12'($urandom) & 12'hFFC};
        3:       a = {8'($urandom), 4'h0, 8'h4 + 8'($urandom_range(1)), 12'($urandom) & 12'hFFC};
        default: a = $urandom & 32'hFFFF_FFFC;
      endcase
      case ($urandom_range(2))
        0: am = 6'h0D;
        1: am = 6'h39;
        default: am = 6'h09;
      endcase
      if ($urandom_range(3) == 0) cpu_wr(int'($urandom_range(WORDS - 1)), $urandom, 4'($urandom));
      slv(a, am, 1'($urandom), 4'($urandom_range(15)), $urandom, int'($urandom_range(4)), "R3 R5 R6 random");
    end
    for (int k = 0; k < 8; k++) cpu_rd(int'($urandom_range(WORDS - 1)), "R1 R10 final contents");
    finish_run();
  end
endmodule